// File: doc/BRIEF.md
# Dual-Channel Sampling ADC Serial Controller

This block sits on the host side of a two-channel, simultaneous-sampling serial ADC and talks to it over three wires: a convert strobe, a serial clock and a serial data line back from the converter. On a frame request it raises the convert strobe, which makes the converter hold both channels and start converting. It then runs 32 serial clock periods and shifts in two signed 14-bit words, channel 0 first. The words it receives belong to the conversion started one frame earlier. The controller hands both words to the system, sign-extended, together with a one-cycle valid strobe.

The same wires also set the converter's power state. With the serial clock held low, two convert pulses put it into nap and four or more put it into sleep. A burst of serial clock periods with the convert strobe low wakes it again. A two-bit host mode request selects the state, and the controller produces whatever pulse sequence gets the converter from its present state to that one. It passes through normal operation when it has to. The first frame after reset or after a wake carries a stale conversion, so it is run but produces no valid strobe.

Top module: `adc_dual_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, adc_conv_o, adc_sclk_o, busy_o and valid_o are all low.
- R2: A start_req seen while idle and in normal mode (mode_req 00) produces one convert pulse, high for CONV_HI_CYC cycles, followed by exactly 32 serial clock periods. The serial clock idles low and is never high while the convert strobe is high.
- R3: Serial clock periods are numbered from 0 after each convert rise. Data is sampled on each falling serial clock edge. Periods WIN_OFS to WIN_OFS+13 carry the channel 0 word, MSB first. Periods 16+WIN_OFS to 16+WIN_OFS+13 carry the channel 1 word, MSB first.
- R4: valid_o is a single-cycle pulse in the first cycle in which busy_o is low after a frame. During that cycle res0_o and res1_o hold the channel 0 and channel 1 words of that frame.
- R5: Each 14-bit word is read as two's complement and sign-extended to OUT_W bits, so -8192 appears as 16'hE000 and 8191 appears as 16'h1FFF.
- R6: The level on adc_sdo_i in serial clock periods outside both word windows has no effect on the results.
- R7: mode_req 01 (nap) while in normal mode produces exactly two convert pulses with the serial clock held low, and no data frame.
- R8: mode_req 10 (sleep) while in normal mode produces SLEEP_PULSES convert pulses (four or more) with the serial clock held low.
- R9: A mode_req that differs from the present low-power mode first produces WAKE_PULSES serial clock periods with the convert strobe low. The block then enters the requested low-power mode, if one was requested, with its convert pulses. Code 11 is treated as normal.
- R10: start_req has no effect while busy_o is high, and no effect while the converter is in nap or sleep.
- R11: When a mode change and start_req occur in the same idle cycle, the mode change is carried out and the start request is dropped.
- R12: The first frame after reset and the first frame after a wake complete normally but produce no valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request for a conversion frame |
| mode_req | input | 2 | Requested power mode: 00 normal, 01 nap, 10 sleep, 11 normal |
| busy_o | output | 1 | High while a frame or power sequence is running |
| valid_o | output | 1 | One-cycle strobe for new results |
| res0_o | output | OUT_W | Channel 0 result, sign-extended |
| res1_o | output | OUT_W | Channel 1 result, sign-extended |
| adc_conv_o | output | 1 | Convert strobe to the converter |
| adc_sclk_o | output | 1 | Serial clock to the converter |
| adc_sdo_i | input | 1 | Serial data from the converter |

## Verification
A start request and a power-mode request can reach the idle sequencer in the same cycle, and only one of them can win. The bench raises start_req and a nap request in the same cycle from normal mode. A converter model counts the convert rises and serial clock rises that follow. The outcome is judged correct if exactly two static-clock convert pulses occur, no serial clock runs, no valid strobe appears and the model ends up in nap. The bench also issues a start in the middle of a running frame and checks that only one convert rise and one result come out.

// File: rtl/adc_dual_pkg.sv
package adc_dual_pkg;

    localparam int RES_W      = 14;
    localparam int HALF_CYC   = 16;
    localparam int FRAME_CYC  = 2 * HALF_CYC;
    localparam int NAP_PULSES = 2;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_NAP    = 2'b01,
        PM_SLEEP  = 2'b10
    } pmode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CONV_HI,
        SQ_CONV_LO,
        SQ_SHIFT,
        SQ_DONE,
        SQ_WAKE
    } seq_state_e;

    typedef enum logic {
        OP_FRAME,
        OP_ENTER
    } seq_op_e;

    typedef struct packed {
        logic signed [RES_W-1:0] ch0;
        logic signed [RES_W-1:0] ch1;
    } res_pair_t;

    // Host code to power mode; the spare code means normal.
    function automatic pmode_e decode_mode(input logic [1:0] code);
        case (code)
            2'b01:   return PM_NAP;
            2'b10:   return PM_SLEEP;
            default: return PM_NORMAL;
        endcase
    endfunction

    // Bit 0: period lies in the channel 0 window; bit 1: in the channel 1 window.
    function automatic logic [1:0] window_hit(input int idx, input int ofs);
        logic [1:0] h;
        h[0] = (idx >= ofs) && (idx < ofs + RES_W);
        h[1] = (idx >= HALF_CYC + ofs) && (idx < HALF_CYC + ofs + RES_W);
        return h;
    endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic fall_now
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;
    logic          at_end;

    assign at_end   = (cnt == CW'(DIV - 1));
    assign fall_now = run && sclk && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (at_end) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_shift_capture.sv
module adc_shift_capture
    import adc_dual_pkg::*;
#(
    parameter int WIN_OFS = 2,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic [IDX_W-1:0] idx,
    input  logic             sdo,
    output res_pair_t        words
);
    logic [1:0] hit;

    assign hit = window_hit(int'(idx), WIN_OFS);

    always_ff @(posedge clk) begin
        if (rst) begin
            words <= '0;
        end else if (cap) begin
            if (hit[0]) words.ch0 <= {words.ch0[RES_W-2:0], sdo};
            if (hit[1]) words.ch1 <= {words.ch1[RES_W-2:0], sdo};
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_dual_pkg::*;
#(
    parameter int CONV_HI_CYC  = 2,
    parameter int CONV_LO_CYC  = 1,
    parameter int SLEEP_PULSES = 4,
    parameter int WAKE_PULSES  = 2,
    parameter int IDX_W        = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic [1:0]       mode_req,
    input  logic             sclk_fall,
    output logic             conv,
    output logic             sclk_run,
    output logic             cap_en,
    output logic [IDX_W-1:0] bit_idx,
    output logic             busy,
    output logic             latch_now
);
    localparam int T_MAX = (CONV_HI_CYC > CONV_LO_CYC) ? CONV_HI_CYC : CONV_LO_CYC;
    localparam int TW    = $clog2(T_MAX + 1);
    localparam int P_MAX = (SLEEP_PULSES > NAP_PULSES) ? SLEEP_PULSES : NAP_PULSES;
    localparam int PW    = $clog2(P_MAX + 1);

    seq_state_e       state;
    seq_op_e          op;
    pmode_e           cur, tgt, req;
    logic             stale;
    logic [TW-1:0]    tcnt;
    logic [PW-1:0]    pcnt;
    logic [IDX_W-1:0] scnt;

    assign req = decode_mode(mode_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            op    <= OP_FRAME;
            cur   <= PM_NORMAL;
            tgt   <= PM_NORMAL;
            stale <= 1'b1;
            tcnt  <= '0;
            pcnt  <= '0;
            scnt  <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    tcnt <= '0;
                    scnt <= '0;
                    if (cur != PM_NORMAL && req != cur) begin
                        state <= SQ_WAKE;
                    end else if (cur == PM_NORMAL && req != PM_NORMAL) begin
                        op    <= OP_ENTER;
                        tgt   <= req;
                        pcnt  <= (req == PM_NAP) ? PW'(NAP_PULSES) : PW'(SLEEP_PULSES);
                        state <= SQ_CONV_HI;
                    end else if (start_req && cur == PM_NORMAL) begin
                        op    <= OP_FRAME;
                        state <= SQ_CONV_HI;
                    end
                end
                SQ_CONV_HI: begin
                    if (tcnt == TW'(CONV_HI_CYC - 1)) begin
                        tcnt  <= '0;
                        state <= SQ_CONV_LO;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                SQ_CONV_LO: begin
                    if (tcnt == TW'(CONV_LO_CYC - 1)) begin
                        tcnt <= '0;
                        if (op == OP_FRAME) begin
                            scnt  <= '0;
                            state <= SQ_SHIFT;
                        end else if (pcnt == PW'(1)) begin
                            cur   <= tgt;
                            state <= SQ_IDLE;
                        end else begin
                            pcnt  <= pcnt - 1'b1;
                            state <= SQ_CONV_HI;
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                SQ_SHIFT: begin
                    if (sclk_fall) begin
                        if (scnt == IDX_W'(FRAME_CYC - 1)) state <= SQ_DONE;
                        else                               scnt  <= scnt + 1'b1;
                    end
                end
                SQ_DONE: begin
                    stale <= 1'b0;
                    state <= SQ_IDLE;
                end
                SQ_WAKE: begin
                    if (sclk_fall) begin
                        if (scnt == IDX_W'(WAKE_PULSES - 1)) begin
                            cur   <= PM_NORMAL;
                            stale <= 1'b1;
                            state <= SQ_IDLE;
                        end else begin
                            scnt <= scnt + 1'b1;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign conv      = (state == SQ_CONV_HI);
    assign sclk_run  = (state == SQ_SHIFT) || (state == SQ_WAKE);
    assign cap_en    = (state == SQ_SHIFT) && sclk_fall;
    assign bit_idx   = scnt;
    assign busy      = (state != SQ_IDLE);
    assign latch_now = (state == SQ_DONE) && !stale;
endmodule

// File: rtl/adc_dual_ctrl.sv
module adc_dual_ctrl
    import adc_dual_pkg::*;
#(
    parameter int SCLK_DIV     = 2,
    parameter int CONV_HI_CYC  = 2,
    parameter int CONV_LO_CYC  = 1,
    parameter int WIN_OFS      = 2,
    parameter int SLEEP_PULSES = 4,
    parameter int WAKE_PULSES  = 2,
    parameter int OUT_W        = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic [1:0]       mode_req,
    output logic             busy_o,
    output logic             valid_o,
    output logic [OUT_W-1:0] res0_o,
    output logic [OUT_W-1:0] res1_o,
    output logic             adc_conv_o,
    output logic             adc_sclk_o,
    input  logic             adc_sdo_i
);
    localparam int CNT_MAX = (FRAME_CYC > WAKE_PULSES) ? FRAME_CYC : WAKE_PULSES;
    localparam int IDX_W   = $clog2(CNT_MAX + 1);
    localparam int EXT_W   = OUT_W - RES_W;

    logic             sclk_run, sclk_fall, cap_en, latch_now;
    logic [IDX_W-1:0] bit_idx;
    res_pair_t        shift_words, held;
    logic             valid_q;

    adc_seq_fsm #(
        .CONV_HI_CYC (CONV_HI_CYC),
        .CONV_LO_CYC (CONV_LO_CYC),
        .SLEEP_PULSES(SLEEP_PULSES),
        .WAKE_PULSES (WAKE_PULSES),
        .IDX_W       (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_req(start_req),
        .mode_req (mode_req),
        .sclk_fall(sclk_fall),
        .conv     (adc_conv_o),
        .sclk_run (sclk_run),
        .cap_en   (cap_en),
        .bit_idx  (bit_idx),
        .busy     (busy_o),
        .latch_now(latch_now)
    );

    adc_sclk_gen #(.DIV(SCLK_DIV)) u_sclk (
        .clk     (clk),
        .rst     (rst),
        .run     (sclk_run),
        .sclk    (adc_sclk_o),
        .fall_now(sclk_fall)
    );

    adc_shift_capture #(.WIN_OFS(WIN_OFS), .IDX_W(IDX_W)) u_cap (
        .clk  (clk),
        .rst  (rst),
        .cap  (cap_en),
        .idx  (bit_idx),
        .sdo  (adc_sdo_i),
        .words(shift_words)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= latch_now;
            if (latch_now) held <= shift_words;
        end
    end

    assign valid_o = valid_q;
    assign res0_o  = {{EXT_W{held.ch0[RES_W-1]}}, held.ch0};
    assign res1_o  = {{EXT_W{held.ch1[RES_W-1]}}, held.ch1};
endmodule

// File: rtl/adc_dual_ctrl_chk.sv
module adc_dual_ctrl_chk
    import adc_dual_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             busy_o,
    input logic             valid_o,
    input logic [OUT_W-1:0] res0_o,
    input logic [OUT_W-1:0] res1_o,
    input logic             adc_conv_o,
    input logic             adc_sclk_o
);
    localparam int SGN_N = OUT_W - RES_W + 1;

    logic       conv_d, sclk_d;
    logic [6:0] rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_d   <= 1'b0;
            sclk_d   <= 1'b0;
            rise_cnt <= '0;
        end else begin
            conv_d <= adc_conv_o;
            sclk_d <= adc_sclk_o;
            if (adc_conv_o && !conv_d)                      rise_cnt <= '0;
            else if (adc_sclk_o && !sclk_d && rise_cnt != '1) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    AST_SCLK_LOW_IN_CONV: assert property (@(posedge clk) disable iff (rst)
        adc_conv_o |-> !adc_sclk_o); // R2
    AST_SCLK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        adc_sclk_o |-> busy_o); // R2
    AST_FRAME_CLOCKS: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (rise_cnt == 7'(FRAME_CYC))); // R2
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R4
    AST_VALID_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> !busy_o); // R4
    AST_SIGN_EXT_CH0: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ($countones(res0_o[OUT_W-1:RES_W-1]) == 0 ||
                     $countones(res0_o[OUT_W-1:RES_W-1]) == SGN_N)); // R5
    AST_SIGN_EXT_CH1: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ($countones(res1_o[OUT_W-1:RES_W-1]) == 0 ||
                     $countones(res1_o[OUT_W-1:RES_W-1]) == SGN_N)); // R5
endmodule

bind adc_dual_ctrl adc_dual_ctrl_chk #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy_o    (busy_o),
    .valid_o   (valid_o),
    .res0_o    (res0_o),
    .res1_o    (res1_o),
    .adc_conv_o(adc_conv_o),
    .adc_sclk_o(adc_sclk_o)
);

// File: tb/tb_adc_dual_ctrl.sv
module tb_adc_dual_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WOFS       = 2;
    localparam int WAKE_N     = 2;
    localparam int SLEEP_N    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_req = 1'b0;
    logic [1:0]  mode_req = 2'b00;
    logic        busy, valid, conv, sclk, sdo;
    logic [15:0] res0, res1;

    int total = 0;
    int bad   = 0;

    adc_dual_ctrl dut (
        .clk(clk), .rst(rst), .start_req(start_req), .mode_req(mode_req),
        .busy_o(busy), .valid_o(valid), .res0_o(res0), .res1_o(res1),
        .adc_conv_o(conv), .adc_sclk_o(sclk), .adc_sdo_i(sdo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Converter model: samples on convert rise, returns previous samples.
    logic signed [13:0] ch0_in = '0, ch1_in = '0;
    logic signed [13:0] m_out0, m_out1, m_smp0, m_smp1;
    logic m_prev_conv, m_prev_sclk, m_sclk_seen, overlap_seen;
    int   m_run, m_k, m_pm;
    int   conv_rises = 0, sclk_rises = 0;

    always @(negedge clk) begin
        if (rst) begin
            m_prev_conv = 0; m_prev_sclk = 0; m_sclk_seen = 1; overlap_seen = 0;
            m_run = 0; m_k = 0; m_pm = 0; sdo = 1'b1;
            m_out0 = '0; m_out1 = '0; m_smp0 = '0; m_smp1 = '0;
        end else begin
            if (conv && !m_prev_conv) begin
                conv_rises++;
                if (m_sclk_seen) m_run = 1; else m_run++;
                m_sclk_seen = 0;
                m_out0 = m_smp0; m_out1 = m_smp1;
                m_smp0 = ch0_in; m_smp1 = ch1_in;
                m_k = 0;
                if (m_run == 2) m_pm = 1; else if (m_run >= 4) m_pm = 2;
            end
            if (sclk && !m_prev_sclk) begin
                sclk_rises++;
                m_sclk_seen = 1;
                m_pm = 0;
                if (m_k >= WOFS && m_k < WOFS + 14)
                    sdo = m_out0[13 - (m_k - WOFS)];
                else if (m_k >= 16 + WOFS && m_k < 16 + WOFS + 14)
                    sdo = m_out1[13 - (m_k - 16 - WOFS)];
                else
                    sdo = 1'b1; // junk outside windows
                m_k++;
            end
            if (conv && sclk) overlap_seen = 1;
            m_prev_conv = conv;
            m_prev_sclk = sclk;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    logic signed [13:0] prev_a = '0, prev_b = '0;

    task automatic run_frame(input logic signed [13:0] a, input logic signed [13:0] b,
                             input int exp_valid, input bit extra_start, input string tag);
        int c0, s0, nv, n;
        logic [15:0] g0, g1;
        logic signed [15:0] e0, e1;
        e0 = prev_a; e1 = prev_b;
        g0 = '0; g1 = '0;
        ch0_in = a; ch1_in = b;
        c0 = conv_rises; s0 = sclk_rises; nv = 0; n = 0;
        start_req = 1'b1;
        step();
        start_req = 1'b0;
        step();
        chk({tag, " R2 busy after start"}, int'(busy), 1);
        while (busy && n < 2000) begin
            if (extra_start && n == 40) start_req = 1'b1;
            step();
            start_req = 1'b0;
            if (valid) begin nv++; g0 = res0; g1 = res1; end
            n++;
        end
        step();
        chk({tag, " R4 valid is one cycle"}, int'(valid), 0);
        chk({tag, " R12/R4 valid count"}, nv, exp_valid);
        chk({tag, " R2 one convert rise"}, conv_rises - c0, 1);
        chk({tag, " R2 sclk periods"}, sclk_rises - s0, 32);
        chk({tag, " R2 sclk low during convert"}, int'(overlap_seen), 0);
        if (exp_valid != 0) begin
            chk({tag, " R3/R5/R6 ch0 result"}, int'(g0), int'(e0[15:0]));
            chk({tag, " R3/R5/R6 ch1 result"}, int'(g1), int'(e1[15:0]));
        end
        if (extra_start) begin
            for (int i = 0; i < 10; i++) begin
                step();
                if (busy) nv = 99;
            end
            chk({tag, " R10 start while busy ignored"}, conv_rises - c0, 1);
        end
        prev_a = a; prev_b = b;
    endtask

    task automatic set_mode(input logic [1:0] m, input bit with_start, input int exp_c,
                            input int exp_s, input int exp_pm, input string tag);
        int c0, s0, nv, idle_n, n;
        c0 = conv_rises; s0 = sclk_rises; nv = 0; idle_n = 0; n = 0;
        mode_req = m;
        start_req = with_start;
        step();
        start_req = 1'b0;
        while (idle_n < 6 && n < 3000) begin
            step();
            if (valid) nv++;
            if (busy) idle_n = 0; else idle_n++;
            n++;
        end
        chk({tag, " convert pulses"}, conv_rises - c0, exp_c);
        chk({tag, " sclk periods"}, sclk_rises - s0, exp_s);
        chk({tag, " no result"}, nv, 0);
        chk({tag, " converter power state"}, m_pm, exp_pm);
        chk({tag, " R2 sclk low during convert"}, int'(overlap_seen), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        chk("R1 conv in reset", int'(conv), 0);
        chk("R1 sclk in reset", int'(sclk), 0);
        chk("R1 busy in reset", int'(busy), 0);
        rst = 1'b0;
        step();
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 valid after reset", int'(valid), 0);
        chk("R1 conv after reset", int'(conv), 0);
    endtask

    task automatic t_start_in_nap();
        int c0;
        c0 = conv_rises;
        start_req = 1'b1;
        step();
        start_req = 1'b0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (busy) c0 = -100;
        end
        chk("R10 start ignored in nap", conv_rises - c0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        run_frame(14'sh0ABC, -14'sd5, 0, 0, "F1 stale after reset R12");
        run_frame(-14'sd8192, 14'sd8191, 1, 0, "F2 R3");
        run_frame(14'sd0, 14'sd0, 1, 0, "F3 extremes R5");
        run_frame(14'sh1555, -14'sd1366, 1, 0, "F4 zeros with junk R6");
        run_frame(14'sd100, -14'sd100, 1, 1, "F5 extra start R10");
        set_mode(2'b01, 0, 2, 0, 1, "R7 nap entry");
        t_start_in_nap();
        set_mode(2'b11, 0, 0, WAKE_N, 0, "R9 wake via code 11");
        run_frame(14'sd7, -14'sd7, 0, 0, "F6 stale after wake R12");
        run_frame(14'sd1, 14'sd2, 1, 0, "F7 R4");
        set_mode(2'b10, 0, SLEEP_N, 0, 2, "R8 sleep entry");
        set_mode(2'b01, 0, 2, WAKE_N, 1, "R9 sleep to nap via wake");
        set_mode(2'b00, 0, 0, WAKE_N, 0, "R9 wake from nap");
        set_mode(2'b01, 1, 2, 0, 1, "R11 mode beats start");
        set_mode(2'b00, 0, 0, WAKE_N, 0, "R9 wake again");
        run_frame(-14'sd1, 14'sd4095, 0, 0, "F8 stale after wake R12");
        run_frame(14'sd3, 14'sd3, 1, 0, "F9 R3");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule